// File: doc/BRIEF.md
# Key-Gated Bank Voltage-Select Guard

This block holds the voltage-select controls for a set of dual-voltage I/O banks and keeps them behind a two-step key sequence. Each bank's control register has one meaningful bit that selects 1.8V operation. Out of reset every bank is in 3.3V operation. Selecting 1.8V while a bank is actually supplied at 3.3V can back-power and damage the pins, so a stray or runaway write must not reach these controls.

There are two simple register ports on one clock:

- **Key port.** Write-only, with two key registers. Software writes the first key and then the second.
- **Protected window.** A small register window, 0x34 bytes, holding one register per bank.

A correct key pair opens the window for exactly one access, either a read or a write. When that access completes, the stored key state is cleared and the window is locked again. For each bank, a 1.8V-enable output follows that bank's stored bit. A status output shows whether the window is currently open.

Top module: `vsel_key_guard`

## Requirements
- R1: After reset, every bank's 1.8V-enable output is 0, the unlocked status is 0, and the read data is 0.
- R2: Two key-port writes open the window: 32'h0000BABA at key offset 0x0, followed by 32'h0000EB10 at key offset 0x4. The unlocked status is 1 in the cycle after the second write.
- R3: An open window admits exactly one protected access. Once it completes, unlocked returns to 0 and the stored first key is cleared, so a lone second-key write does not reopen the window.
- R4: These key writes clear all key state, including an open window:
  - a key write carrying a wrong value;
  - a second-key write made without a stored valid first key.
- R5: A protected write while locked changes no bank register.
- R6: A protected read while locked returns 0 and leaves the block locked.
- R7: Bank registers sit at window offsets 0x0C, 0x10, 0x1C and 0x20, which drive 1.8V-enable bits 0, 1, 2 and 3 in that order. Only data bit 2 is stored. All other bits read 0 and ignore writes.
- R8: Read data is registered and appears in the cycle after the read is issued. In every other cycle it is 0.
- R9: An access to a window offset with no bank register consumes the grant. A read there returns 0, and a write there changes nothing.
- R10: A 1.8V-enable output changes only on an accepted unlocked write.
- R11: When a protected access and a key write occur in the same cycle, the access is handled and the key write is dropped. The window ends up locked with no stored first key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr_en | input | 1 | Key-port write strobe |
| key_addr | input | 3 | Key register byte offset |
| key_wdata | input | 32 | Key write data |
| pw_en | input | 1 | Protected-window access strobe |
| pw_we | input | 1 | 1 = write, 0 = read |
| pw_addr | input | 6 | Protected-window byte offset |
| pw_wdata | input | 32 | Protected write data |
| pw_rdata | output | 32 | Protected read data, one cycle after the read |
| v18_en | output | 4 | Per-bank 1.8V enable |
| unlocked | output | 1 | Window currently open for one access |

## Verification
The unlock logic is tried with five kinds of key sequence:

- the correct pair;
- a wrong first value;
- a wrong second value;
- the keys in reverse order;
- a lone second key after a completed grant.

Together these separate an unlock that checks order and value from one that only counts writes. Protected reads and writes are issued with the window locked, immediately after an unlock, and a second time after the grant has been used, which shows the grant is used up by one access. All-ones write data and an offset with no bank register show that only bit 2 is stored and that any access consumes the grant. A key write in the same cycle as an access shows which of the two wins.

// File: rtl/vsel_key_guard.sv
module vsel_key_guard #(
  parameter int                        DATA_W     = 32,
  parameter int                        WIN_BYTES  = 52,
  parameter int                        KEY_AW     = 3,
  parameter int                        NUM_BANKS  = 4,
  parameter int                        OFF_W      = 8,
  parameter logic [NUM_BANKS*OFF_W-1:0] BANK_OFFS = {8'h20, 8'h1C, 8'h10, 8'h0C},
  parameter int                        V18_BIT    = 2,
  parameter logic [KEY_AW-1:0]         KEY1_OFF   = 3'h0,
  parameter logic [KEY_AW-1:0]         KEY2_OFF   = 3'h4,
  parameter logic [DATA_W-1:0]         KEY1_VAL   = 32'h0000_BABA,
  parameter logic [DATA_W-1:0]         KEY2_VAL   = 32'h0000_EB10,
  localparam int                       PAW        = $clog2(WIN_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 key_wr_en,
  input  logic [KEY_AW-1:0]    key_addr,
  input  logic [DATA_W-1:0]    key_wdata,
  input  logic                 pw_en,
  input  logic                 pw_we,
  input  logic [PAW-1:0]       pw_addr,
  input  logic [DATA_W-1:0]    pw_wdata,
  output logic [DATA_W-1:0]    pw_rdata,
  output logic [NUM_BANKS-1:0] v18_en,
  output logic                 unlocked
);

  logic                 key1_ok;
  logic                 open_q;
  logic [NUM_BANKS-1:0] bank_q;
  logic [NUM_BANKS-1:0] hit;
  logic [DATA_W-1:0]    rdata_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
    assign hit[g] = (OFF_W'(pw_addr) == BANK_OFFS[g*OFF_W +: OFF_W]);
  end

  wire grant = pw_en && open_q;
  wire rd_ok = grant && !pw_we;
  wire wr_ok = grant && pw_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key1_ok <= 1'b0;
      open_q  <= 1'b0;
      bank_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (rd_ok) rdata_q[V18_BIT] <= |(hit & bank_q);
      if (pw_en) begin
        for (int i = 0; i < NUM_BANKS; i++)
          if (wr_ok && hit[i]) bank_q[i] <= pw_wdata[V18_BIT];
        key1_ok <= 1'b0;
        open_q  <= 1'b0;
      end else if (key_wr_en) begin
        if (key_addr == KEY1_OFF) begin
          key1_ok <= (key_wdata == KEY1_VAL);
          open_q  <= 1'b0;
        end else if (key_addr == KEY2_OFF) begin
          open_q  <= key1_ok && (key_wdata == KEY2_VAL);
          key1_ok <= 1'b0;
        end
      end
    end
  end

  assign pw_rdata = rdata_q;
  assign v18_en   = bank_q;
  assign unlocked = open_q;

endmodule

// File: rtl/vsel_key_guard_chk.sv
module vsel_key_guard_chk #(
  parameter int                 DATA_W    = 32,
  parameter int                 KEY_AW    = 3,
  parameter int                 NUM_BANKS = 4,
  parameter int                 PAW       = 6,
  parameter int                 V18_BIT   = 2,
  parameter logic [KEY_AW-1:0]  KEY2_OFF  = 3'h4,
  parameter logic [DATA_W-1:0]  KEY2_VAL  = 32'h0000_EB10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 key_wr_en,
  input logic [KEY_AW-1:0]    key_addr,
  input logic [DATA_W-1:0]    key_wdata,
  input logic                 pw_en,
  input logic                 pw_we,
  input logic [DATA_W-1:0]    pw_rdata,
  input logic [NUM_BANKS-1:0] v18_en,
  input logic                 unlocked
);

  a_r2_unlock_needs_key2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr_en && !pw_en && key_addr == KEY2_OFF && key_wdata == KEY2_VAL));

  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && pw_en) |=> !unlocked);

  a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && pw_en) |=> $stable(v18_en));

  a_r6_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && pw_en && !pw_we) |=> (pw_rdata == '0 && !unlocked));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_rdata & ~(DATA_W'(1) << V18_BIT)) == '0);

  a_r8_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(pw_en && !pw_we) |=> pw_rdata == '0);

  a_r10_change_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v18_en) |-> $past(unlocked && pw_en && pw_we));

endmodule

bind vsel_key_guard vsel_key_guard_chk #(
  .DATA_W(DATA_W), .KEY_AW(KEY_AW), .NUM_BANKS(NUM_BANKS), .PAW(PAW),
  .V18_BIT(V18_BIT), .KEY2_OFF(KEY2_OFF), .KEY2_VAL(KEY2_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_addr(key_addr),
  .key_wdata(key_wdata), .pw_en(pw_en), .pw_we(pw_we), .pw_rdata(pw_rdata),
  .v18_en(v18_en), .unlocked(unlocked)
);

// File: tb/sim_vsel_key_guard.sv
`timescale 1ns/1ps
module sim_vsel_key_guard;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        key_wr_en = 0;
  logic [2:0]  key_addr = '0;
  logic [31:0] key_wdata = '0;
  logic        pw_en = 0;
  logic        pw_we = 0;
  logic [5:0]  pw_addr = '0;
  logic [31:0] pw_wdata = '0;
  logic [31:0] pw_rdata;
  logic [3:0]  v18_en;
  logic        unlocked;

  always #4 clk = ~clk;

  vsel_key_guard u0 (.*);

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic rd_q = 0;
  bit done = 0;

  always @(posedge clk) rd_q <= pw_en && !pw_we;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pw_rdata !== e.val) begin
        errors++;
        $display("FAIL %s: rdata actual=%h expected=%h", e.req, pw_rdata, e.val);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kw(input logic [2:0] a, input logic [31:0] d);
    key_wr_en = 1; key_addr = a; key_wdata = d;
    @(negedge clk);
    key_wr_en = 0;
  endtask

  task automatic unlock();
    kw(3'h0, 32'h0000_BABA);
    kw(3'h4, 32'h0000_EB10);
  endtask

  task automatic pwr(input logic [5:0] a, input logic [31:0] d);
    pw_en = 1; pw_we = 1; pw_addr = a; pw_wdata = d;
    @(negedge clk);
    pw_en = 0; pw_we = 0;
  endtask

  task automatic prd(input logic [5:0] a, input logic [31:0] exp, input string req);
    exp_t e;
    e.val = exp; e.req = req;
    exp_q.push_back(e);
    pw_en = 1; pw_we = 0; pw_addr = a;
    @(negedge clk);
    pw_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(32'(v18_en), 0, "R1 v18_en");
    chk(32'(unlocked), 0, "R1 unlocked");
    chk(pw_rdata, 0, "R1 rdata");

    unlock();
    chk(32'(unlocked), 1, "R2 unlock after pair");
    pwr(6'h10, 32'hFFFF_FFFF);
    chk(32'(v18_en), 4'b0010, "R7 bank1 written");
    chk(32'(unlocked), 0, "R3 relock after write");

    unlock();
    prd(6'h10, 32'h4, "R8 R7 read bank1");
    @(negedge clk);
    chk(32'(unlocked), 0, "R3 relock after read");

    pwr(6'h0C, 32'h4);
    chk(32'(v18_en), 4'b0010, "R5 locked write ignored");
    kw(3'h4, 32'h0000_EB10);
    chk(32'(unlocked), 0, "R3 lone key2 after grant");

    prd(6'h10, 32'h0, "R6 locked read zero");
    @(negedge clk);
    chk(32'(unlocked), 0, "R6 stays locked");

    kw(3'h0, 32'h0000_BABB); kw(3'h4, 32'h0000_EB10);
    chk(32'(unlocked), 0, "R4 wrong key1");
    kw(3'h0, 32'h0000_BABA); kw(3'h4, 32'h0000_EB11);
    chk(32'(unlocked), 0, "R4 wrong key2");
    kw(3'h4, 32'h0000_EB10); kw(3'h0, 32'h0000_BABA);
    chk(32'(unlocked), 0, "R4 reversed order");
    kw(3'h4, 32'h0000_EB10);
    chk(32'(unlocked), 1, "R2 key2 after stored key1");
    kw(3'h0, 32'h0);
    chk(32'(unlocked), 0, "R4 wrong key clears open window");

    unlock();
    prd(6'h14, 32'h0, "R9 undefined read");
    @(negedge clk);
    chk(32'(unlocked), 0, "R9 undefined read consumes");
    unlock();
    pwr(6'h14, 32'hFFFF_FFFF);
    chk(32'(v18_en), 4'b0010, "R9 R10 undefined write");
    chk(32'(unlocked), 0, "R9 undefined write consumes");

    unlock(); pwr(6'h0C, 32'h4);
    unlock(); pwr(6'h1C, 32'h4);
    unlock(); pwr(6'h20, 32'h0000_0004);
    unlock(); pwr(6'h10, 32'hFFFF_FFFB);
    chk(32'(v18_en), 4'b1101, "R7 bank mapping");
    unlock();
    prd(6'h20, 32'h4, "R7 read bank3");
    unlock();
    prd(6'h10, 32'h0, "R7 read bank1 cleared");
    @(negedge clk);

    unlock();
    key_wr_en = 1; key_addr = 3'h0; key_wdata = 32'h0000_BABA;
    pw_en = 1; pw_we = 1; pw_addr = 6'h20; pw_wdata = 32'h0;
    @(negedge clk);
    key_wr_en = 0; pw_en = 0; pw_we = 0;
    chk(32'(v18_en), 4'b0101, "R11 access handled");
    chk(32'(unlocked), 0, "R11 locked");
    kw(3'h4, 32'h0000_EB10);
    chk(32'(unlocked), 0, "R11 key1 dropped");

    repeat (2) @(negedge clk);
    chk(32'(exp_q.size()), 0, "R8 all reads observed");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule